// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a data cache placed between a processor's word request port and a single-word memory port. Each line holds a valid flag, a tag and a block of four 32-bit words. A read that hits returns its word in the same cycle. Any miss, read or write, holds the processor stalled while the whole block is loaded from memory. The loaded line is then written into the array and the held request finishes as a hit.

Writes go through to memory. A write hit updates the cached word and places an address/data entry in a small first-in first-out write buffer. The buffer empties to memory in the background whenever the memory port is free. The processor waits only when it writes while the buffer is full. A refill is never started while buffered writes are still pending, so a refill can never return data older than a write the processor has already made.

The memory side uses a request/acknowledge handshake and moves one word per acknowledged beat. The processor holds a request with its address and data until a cycle in which the stall output is low. That cycle is the one in which the request completes.

Top module: `dmc_cache`

## Requirements
- R1: After reset, every line is invalid. With no request present, `cpu_stall` and `mem_req` are low. The first access to any address is a miss.
- R2: The byte address is split as follows: bits [3:2] select the word within the block, bits [9:4] are the line index (default of 64 lines), and bits [31:10] are the tag. A hit needs the line's valid flag set and all tag bits equal. An address that differs from a cached one only in bit 31 misses.
- R3: A read hit keeps `cpu_stall` low and drives `cpu_rdata` in the same cycle. The value is the word of the line selected by address bits [3:2].
- R4: A read miss raises `cpu_stall` and issues exactly four read beats (`mem_we` low). The beats go to the block base plus 0, 4, 8 and 12, in that order. The request then completes with the requested word.
- R5: A write hit with the buffer not full completes with `cpu_stall` low. It updates the cached word, so a later read of that address returns the new data.
- R6: Buffered writes leave on `mem_req` with `mem_we` high, one entry per acknowledge, in the order the processor issued them. Each carries its original address and data.
- R7: When the write buffer already holds four entries, a further write is stalled until an entry has left for memory.
- R8: Every write accepted before a miss reaches memory before the first read beat of that miss's refill.
- R9: A write miss first refills the whole block from memory and then merges the written word. The other three words read back with memory's values and the written word reads back with the new data. The write is also forwarded to memory.
- R10: An access whose index matches a valid line but whose tag differs replaces that line. A following access to the evicted block misses again and returns that block's current memory value.
- R11: Once `mem_req` is raised, it stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request present; held until a cycle with `cpu_stall` low |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Word-aligned byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid in the completing cycle of a read |
| cpu_stall | output | 1 | High while the present request cannot complete |
| mem_req | output | 1 | Memory beat requested |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 32 | Write beat data |
| mem_rdata | input | 32 | Read beat data, valid with `mem_ack` |
| mem_ack | input | 1 | Beat accepted in this cycle |

## Verification
A read hit or an accepted write hit is due combinationally, in the cycle the request is presented. The bench drives inputs at the falling edge and samples `cpu_stall` and `cpu_rdata` one time unit later, before the next rising edge. A miss completes in the first cycle after the rising edge that takes the fourth read acknowledge. The bench therefore polls the stall at each falling edge and takes the read data only in the first cycle where the stall is low. Memory ordering is checked against a log the bench's memory model writes at each acknowledge. Buffer draining is awaited by watching `mem_req` stay low before memory contents are compared.

// File: rtl/dmc_pkg.sv
// Shared types for the direct-mapped write-through cache.
// Assumes 32-bit byte addresses and 32-bit words.
package dmc_pkg;
    localparam int ADDR_W = 32;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_FILL
    } ctl_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } wb_entry_t;
endpackage

// File: rtl/dmc_line_store.sv
// Line array: valid flags, tags and data blocks, read asynchronously by index.
// Assumes a whole-line fill and a single-word write never occur in the same cycle.
module dmc_line_store
    import dmc_pkg::*;
#(
    parameter int INDEX_W = 6,
    parameter int WORDS   = 4,
    parameter int TAG_W   = 22
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [INDEX_W-1:0]          rd_idx,
    output logic                        rd_valid,
    output logic [TAG_W-1:0]            rd_tag,
    output logic [WORDS*WORD_W-1:0]     rd_line,
    input  logic                        fill_en,
    input  logic [INDEX_W-1:0]          fill_idx,
    input  logic [TAG_W-1:0]            fill_tag,
    input  logic [WORDS*WORD_W-1:0]     fill_line,
    input  logic                        wr_en,
    input  logic [INDEX_W-1:0]          wr_idx,
    input  logic [$clog2(WORDS)-1:0]    wr_off,
    input  logic [WORD_W-1:0]           wr_word
);
    localparam int LINES  = 1 << INDEX_W;
    localparam int LINE_W = WORDS * WORD_W;

    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [LINE_W-1:0] data_q [LINES];

    // Asynchronous lookup of the addressed line.
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
        rd_line  = data_q[rd_idx];
    end

    // Valid flags: cleared by reset, set by a completed fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (fill_en) begin
            valid_q[fill_idx] <= 1'b1;
        end
    end

    // Tag and data storage: whole-line fill or single-word merge.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_idx]  <= fill_tag;
            data_q[fill_idx] <= fill_line;
        end else if (wr_en) begin
            data_q[wr_idx][wr_off*WORD_W +: WORD_W] <= wr_word;
        end
    end

    // R9: the merge of a write miss follows its fill and never collides with it.
    assert_fill_word_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_en && wr_en));
endmodule

// File: rtl/dmc_wbuf.sv
// First-in first-out posted write buffer with simultaneous push and pop.
// Assumes the user never pushes when full nor pops when empty.
module dmc_wbuf
    import dmc_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  wb_entry_t push_entry,
    input  logic      pop,
    output wb_entry_t head,
    output logic      empty,
    output logic      full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    wb_entry_t         slot_q [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0]  count_q;

    // Status and head entry.
    always_comb begin
        empty = (count_q == '0);
        full  = (count_q == CNT_W'(DEPTH));
        head  = slot_q[rd_ptr_q];
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push) wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH-1)) ? '0 : wr_ptr_q + 1'b1;
            if (pop)  rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH-1)) ? '0 : rd_ptr_q + 1'b1;
            if (push && !pop)      count_q <= count_q + 1'b1;
            else if (pop && !push) count_q <= count_q - 1'b1;
        end
    end

    // Entry storage.
    always_ff @(posedge clk) begin
        if (push) slot_q[wr_ptr_q] <= push_entry;
    end

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/dmc_cache.sv
// Direct-mapped write-through data cache with four-word lines and a posted
// write buffer. Any miss drains the buffer, refills the whole line one word
// per memory beat, then lets the held request complete as a hit.
// Assumes word-aligned addresses and a processor that holds its request
// until cpu_stall is low.
module dmc_cache
    import dmc_pkg::*;
#(
    parameter int INDEX_W  = 6,
    parameter int WORDS    = 4,
    parameter int WB_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam int BYTE_W  = 2;
    localparam int OFF_W   = $clog2(WORDS);
    localparam int TAG_W   = ADDR_W - INDEX_W - OFF_W - BYTE_W;
    localparam int LINE_W  = WORDS * WORD_W;
    localparam int BLK_W   = ADDR_W - OFF_W - BYTE_W;

    ctl_state_t         state_q, state_d;
    logic [BLK_W-1:0]   miss_blk_q;
    logic [OFF_W-1:0]   beat_q;
    logic [LINE_W-1:0]  fill_buf_q, fill_line;

    logic [OFF_W-1:0]   a_off;
    logic [INDEX_W-1:0] a_idx;
    logic [TAG_W-1:0]   a_tag;
    logic               rd_valid, hit, in_idle, in_fill;
    logic [TAG_W-1:0]   rd_tag;
    logic [LINE_W-1:0]  rd_line;
    logic               wr_en, fill_en, last_beat, miss_start;
    logic               wb_pop, wb_empty, wb_full;
    wb_entry_t          wb_head, wb_in;

    // Address split and hit detection.
    always_comb begin
        a_off   = cpu_addr[BYTE_W +: OFF_W];
        a_idx   = cpu_addr[BYTE_W+OFF_W +: INDEX_W];
        a_tag   = cpu_addr[ADDR_W-1 -: TAG_W];
        hit     = rd_valid && (rd_tag == a_tag);
        in_idle = (state_q == ST_IDLE);
        in_fill = (state_q == ST_FILL);
    end

    // Processor side: word select, stall and write-hit acceptance.
    always_comb begin
        cpu_rdata  = rd_line[a_off*WORD_W +: WORD_W];
        cpu_stall  = cpu_req && (!in_idle || !hit || (cpu_we && wb_full));
        wr_en      = cpu_req && cpu_we && !cpu_stall;
        miss_start = cpu_req && in_idle && !hit;
        wb_in.addr = cpu_addr;
        wb_in.data = cpu_wdata;
    end

    // Memory side: refill beats own the port in FILL, the write buffer otherwise.
    always_comb begin
        mem_req   = in_fill || !wb_empty;
        mem_we    = !in_fill;
        mem_addr  = in_fill ? {miss_blk_q, beat_q, {BYTE_W{1'b0}}} : wb_head.addr;
        mem_wdata = wb_head.data;
        wb_pop    = !in_fill && !wb_empty && mem_ack;
        last_beat = (beat_q == OFF_W'(WORDS-1));
        fill_en   = in_fill && mem_ack && last_beat;
    end

    // Completed line: collected beats plus the word arriving now.
    always_comb begin
        fill_line = fill_buf_q;
        fill_line[beat_q*WORD_W +: WORD_W] = mem_rdata;
    end

    // Control sequencing: miss -> drain buffer -> refill -> idle.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (miss_start) state_d = wb_empty ? ST_FILL : ST_DRAIN;
            ST_DRAIN: if (wb_empty)   state_d = ST_FILL;
            ST_FILL:  if (fill_en)    state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State, missed block address and beat counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            miss_blk_q <= '0;
            beat_q     <= '0;
        end else begin
            state_q <= state_d;
            if (miss_start) begin
                miss_blk_q <= cpu_addr[ADDR_W-1:BYTE_W+OFF_W];
                beat_q     <= '0;
            end else if (in_fill && mem_ack) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    // Refill word collection.
    always_ff @(posedge clk) begin
        if (in_fill && mem_ack) fill_buf_q <= fill_line;
    end

    dmc_line_store #(
        .INDEX_W (INDEX_W),
        .WORDS   (WORDS),
        .TAG_W   (TAG_W)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (a_idx),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_line   (rd_line),
        .fill_en   (fill_en),
        .fill_idx  (miss_blk_q[INDEX_W-1:0]),
        .fill_tag  (miss_blk_q[BLK_W-1 -: TAG_W]),
        .fill_line (fill_line),
        .wr_en     (wr_en),
        .wr_idx    (a_idx),
        .wr_off    (a_off),
        .wr_word   (cpu_wdata)
    );

    dmc_wbuf #(
        .DEPTH (WB_DEPTH)
    ) wbuf_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (wr_en),
        .push_entry (wb_in),
        .pop        (wb_pop),
        .head       (wb_head),
        .empty      (wb_empty),
        .full       (wb_full)
    );

    // R8: a refill runs only with the write buffer empty.
    assert_refill_after_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_fill |-> wb_empty);
    // R4: refill beats are reads.
    assert_refill_is_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fill && mem_req) |-> !mem_we);
    // R11: an unacknowledged beat is held unchanged.
    assert_beat_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));
    // R1: reset leaves the controller idle with no memory traffic.
    assert_idle_after_reset_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!mem_req && in_idle));
endmodule

// File: tb/dmc_cache_tb.sv
// Directed bench for dmc_cache with a behavioural word memory.
module dmc_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_stall;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    int mem_lat = 1;
    int wait_cnt = 0;
    int hs_err = 0;

    logic [31:0] mem_store [logic [31:0]];
    logic [31:0] shadow    [logic [31:0]];
    logic        ev_we   [$];
    logic [31:0] ev_addr [$];
    logic [31:0] ev_data [$];

    always #2 clk = ~clk;   // 250 MHz

    dmc_cache dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    function automatic logic [31:0] init_val(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h0BAD_F00D;
    endfunction

    function automatic logic [31:0] mem_val(input logic [31:0] a);
        if (mem_store.exists(a)) return mem_store[a];
        return init_val(a);
    endfunction

    function automatic logic [31:0] exp_val(input logic [31:0] a);
        if (shadow.exists(a)) return shadow[a];
        return init_val(a);
    endfunction

    // Memory model: acknowledge after mem_lat waiting cycles, log each beat.
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (rst_n && mem_req && !mem_ack) begin
            if (wait_cnt >= mem_lat) begin
                wait_cnt <= 0;
                mem_ack  <= 1'b1;
                ev_we.push_back(mem_we);
                ev_addr.push_back(mem_addr);
                ev_data.push_back(mem_wdata);
                if (mem_we) mem_store[mem_addr] = mem_wdata;
                else        mem_rdata <= mem_val(mem_addr);
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    // R11 monitor: a pending beat must stay unchanged.
    logic        p_req = 1'b0, p_ack = 1'b0, p_we = 1'b0;
    logic [31:0] p_addr = '0, p_data = '0;
    always @(posedge clk) begin
        if (rst_n && p_req && !p_ack &&
            (!mem_req || mem_addr != p_addr || mem_we != p_we || mem_wdata != p_data))
            hs_err++;
        p_req <= rst_n && mem_req; p_ack <= mem_ack; p_we <= mem_we;
        p_addr <= mem_addr; p_data <= mem_wdata;
    end

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // One processor access; returns read data and the number of stalled cycles.
    task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output int cyc);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        cyc = 0;
        #1;
        while (cpu_stall) begin
            @(negedge clk);
            #1;
            cyc++;
        end
        rd = cpu_rdata;
        if (we) shadow[a] = d;
        @(posedge clk);
        #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic wait_drain();
        int quiet = 0;
        while (quiet < 3) begin
            @(negedge clk);
            quiet = mem_req ? 0 : quiet + 1;
        end
    endtask

    // R1: idle outputs after reset, first access misses.
    task automatic t_reset();
        logic [31:0] rd; int cyc;
        @(negedge clk);
        chk("R1", "stall idle", {31'b0, cpu_stall}, 32'd0);
        chk("R1", "mem_req idle", {31'b0, mem_req}, 32'd0);
        access(1'b0, 32'h0000_0040, '0, rd, cyc);
        chk("R1", "first access misses", {31'b0, cyc > 0}, 32'd1);
        chk("R1", "first read data", rd, exp_val(32'h40));
    endtask

    // R4/R3: read miss refill order, then hits on every word of the block.
    task automatic t_read_miss_hit();
        logic [31:0] rd; int cyc; int base;
        base = ev_addr.size();
        access(1'b0, 32'h0000_0108, '0, rd, cyc);
        chk("R4", "miss stalls", {31'b0, cyc > 0}, 32'd1);
        chk("R4", "miss data", rd, exp_val(32'h108));
        chk("R4", "beat count", ev_addr.size() - base, 32'd4);
        for (int k = 0; k < 4; k++) begin
            chk("R4", "beat address", ev_addr[base+k], 32'h100 + 32'(k*4));
            chk("R4", "beat is read", {31'b0, ev_we[base+k]}, 32'd0);
        end
        for (int k = 0; k < 4; k++) begin
            access(1'b0, 32'h100 + 32'(k*4), '0, rd, cyc);
            chk("R3", "hit no stall", cyc, 32'd0);
            chk("R3", "hit word select", rd, exp_val(32'h100 + 32'(k*4)));
        end
        chk("R3", "hits cause no beats", ev_addr.size() - base, 32'd4);
    endtask

    // R5/R6: write hit, readback, and write-through to memory.
    task automatic t_write_hit();
        logic [31:0] rd; int cyc;
        access(1'b1, 32'h104, 32'hCAFE_0001, rd, cyc);
        chk("R5", "write hit no stall", cyc, 32'd0);
        access(1'b0, 32'h104, '0, rd, cyc);
        chk("R5", "readback hit", {31'b0, cyc == 0}, 32'd1);
        chk("R5", "readback data", rd, 32'hCAFE_0001);
        wait_drain();
        chk("R6", "memory updated", mem_val(32'h104), 32'hCAFE_0001);
        chk("R6", "last beat is write", {31'b0, ev_we[ev_we.size()-1]}, 32'd1);
    endtask

    // R7/R6: fill the buffer against slow memory, check stall and drain order.
    task automatic t_buffer_full();
        logic [31:0] rd; int cyc; int base;
        logic [31:0] adr [5];
        adr = '{32'h100, 32'h104, 32'h108, 32'h10C, 32'h100};
        wait_drain();
        mem_lat = 6;
        base = ev_addr.size();
        for (int k = 0; k < 5; k++) begin
            access(1'b1, adr[k], 32'hB000_0000 + 32'(k), rd, cyc);
            if (k < 4) chk("R7", "write accepted", cyc, 32'd0);
            else       chk("R7", "fifth write stalls", {31'b0, cyc > 0}, 32'd1);
        end
        wait_drain();
        mem_lat = 1;
        chk("R6", "write beats drained", ev_addr.size() - base, 32'd5);
        for (int k = 0; k < 5; k++) begin
            chk("R6", "drain address order", ev_addr[base+k], adr[k]);
            chk("R6", "drain data order", ev_data[base+k], 32'hB000_0000 + 32'(k));
        end
        access(1'b0, 32'h100, '0, rd, cyc);
        chk("R5", "latest write cached", rd, 32'hB000_0004);
    endtask

    // R8/R10: pending write reaches memory before a conflicting refill.
    task automatic t_drain_before_refill();
        logic [31:0] rd; int cyc; int base; int first_rd; int wr_pos;
        wait_drain();
        mem_lat = 4;
        base = ev_addr.size();
        access(1'b1, 32'h108, 32'hD00D_0008, rd, cyc);
        access(1'b0, 32'h0000_0500, '0, rd, cyc);   // same index, other tag
        mem_lat = 1;
        chk("R10", "conflict miss", {31'b0, cyc > 0}, 32'd1);
        chk("R10", "conflict data", rd, exp_val(32'h500));
        first_rd = -1; wr_pos = -1;
        for (int k = base; k < ev_addr.size(); k++) begin
            if (ev_we[k] && ev_addr[k] == 32'h108 && wr_pos < 0) wr_pos = k;
            if (!ev_we[k] && first_rd < 0) first_rd = k;
        end
        chk("R8", "write before refill", {31'b0, wr_pos >= 0 && wr_pos < first_rd}, 32'd1);
        access(1'b0, 32'h108, '0, rd, cyc);
        chk("R10", "evicted block misses", {31'b0, cyc > 0}, 32'd1);
        chk("R8", "no stale refill", rd, 32'hD00D_0008);
    endtask

    // R9: write miss refills then merges.
    task automatic t_write_miss();
        logic [31:0] rd; int cyc; int base;
        base = ev_addr.size();
        access(1'b1, 32'h0000_5A48, 32'h5EED_5A48, rd, cyc);
        chk("R9", "write miss stalls", {31'b0, cyc > 0}, 32'd1);
        chk("R9", "block read first", ev_addr[base], 32'h5A40);
        for (int k = 0; k < 4; k++) begin
            access(1'b0, 32'h5A40 + 32'(k*4), '0, rd, cyc);
            chk("R9", "line hit after merge", cyc, 32'd0);
            chk("R9", "merged line word", rd, exp_val(32'h5A40 + 32'(k*4)));
        end
        wait_drain();
        chk("R9", "write forwarded", mem_val(32'h5A48), 32'h5EED_5A48);
    endtask

    // R2: a difference in the top address bit alone is a different block.
    task automatic t_tag_msb();
        logic [31:0] rd; int cyc;
        access(1'b0, 32'h0000_5A44, '0, rd, cyc);
        chk("R2", "cached block hits", cyc, 32'd0);
        access(1'b0, 32'h8000_5A44, '0, rd, cyc);
        chk("R2", "msb tag miss", {31'b0, cyc > 0}, 32'd1);
        chk("R2", "msb tag data", rd, exp_val(32'h8000_5A44));
        access(1'b0, 32'h8000_5A4C, '0, rd, cyc);
        chk("R2", "offset bits select word", rd, exp_val(32'h8000_5A4C));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_read_miss_hit();
        t_write_hit();
        t_buffer_full();
        t_drain_before_refill();
        t_write_miss();
        t_tag_msb();
        wait_drain();
        chk("R11", "held beats", hs_err, 32'd0);
        finish_run();
    end
endmodule